// File: doc/BRIEF.md
# Victim Buffer Fill Controller

This block sits beside the tag array of a direct-mapped cache and owns one victim-buffer slot. The slot holds the line address of a dirty line that a fill has displaced and that is waiting to be written back. For every request the surrounding cache presents the request address, whether it is a write, whether it is a burst, and the contents of the indexed tag entry: valid bit, dirty bit and stored tag. The block then decides, one cycle later, on one of four outcomes:

- let a line fill begin,
- refuse the fill,
- answer the request from the victim slot,
- do nothing, because the request hit the cache.

While a fill is in progress the block keeps a copy of the displaced entry's tag, valid bit, dirty bit and index. If the bus retries the fill, it hands that copy back so the tag array can be repaired. When the fill had put a dirty victim in the slot, a retry also empties the slot. A separate write-back engine signals when the slot's data has been drained. The data RAM is outside this block; lines are identified only by their address.

Address layout: the low `OFF_W` bits are the byte offset, the next `IDX_W` bits are the set index, and the remaining high bits are the tag. The line address is the tag and index together, with the tag in the high part.

Top module: `cob_fill_ctl`

## Requirements
- R1: After reset, fill_start, fill_cancel, cob_serve, restore_vld and cob_valid are all 0.
- R2: A request whose tag matches a valid indexed entry is a cache hit. It gives no fill_start, fill_cancel or cob_serve, and leaves the slot unchanged.
- R3: A miss whose indexed entry is invalid or clean pulses fill_start one cycle after the request. It leaves the slot unchanged and is never refused, even when the slot is full.
- R4: A miss whose indexed entry is valid and dirty, with an empty slot, pulses fill_start. In the same cycle cob_valid becomes 1, and cob_line becomes {entry tag, request index}.
- R5: A miss with a valid dirty entry while the slot is full pulses fill_cancel, with no fill_start and the slot unchanged. The exception is the R6 case.
- R6: A write miss whose line address equals cob_line, with a full slot and a dirty entry, pulses fill_start. The slot then holds the newly displaced line.
- R7: A burst read that misses the cache and whose line address equals cob_line pulses cob_serve. It gives no fill_start or fill_cancel, and the slot is unchanged.
- R8: retry during a fill that loaded the slot pulses fill_cancel and restore_vld together, and clears cob_valid in that cycle. restore_tag, restore_valid, restore_dirty and restore_idx then show the displaced entry as it was at fill start. This holds also when the fill was the R6 write.
- R9: retry during a fill of a clean or invalid entry pulses fill_cancel without restore_vld and leaves the slot unchanged.
- R10: drain_done clears cob_valid on the next edge while no slot-loading fill is in progress. It is ignored during such a fill.
- R11: fill_done ends a fill with no fill_cancel or restore_vld. Requests presented while a fill is in progress give no outputs.
- R12: When retry and fill_done arrive in the same cycle, retry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst transfer |
| lk_valid | input | 1 | Indexed tag entry valid |
| lk_dirty | input | 1 | Indexed tag entry dirty |
| lk_tag | input | TAG_W | Indexed tag entry tag |
| retry | input | 1 | Bus retry of the fill in progress |
| fill_done | input | 1 | Fill in progress completed |
| drain_done | input | 1 | Victim slot written back |
| fill_start | output | 1 | Pulse: fill begins |
| fill_cancel | output | 1 | Pulse: fill refused or retried |
| cob_serve | output | 1 | Pulse: answer request from victim slot |
| restore_vld | output | 1 | Pulse: write restore fields into tag array |
| restore_tag | output | TAG_W | Tag to restore |
| restore_valid | output | 1 | Valid bit to restore |
| restore_dirty | output | 1 | Dirty bit to restore |
| restore_idx | output | IDX_W | Index of entry to restore |
| cob_valid | output | 1 | Victim slot occupied |
| cob_line | output | TAG_W+IDX_W | Line address in victim slot |

## Verification
The hardest situation to reach is a retry that lands on the write fill admitted by the R6 exception. To get there, the slot must first be filled by a dirty displacement and must survive a completed fill. A later write must then aim at exactly that slot line while its set still shows a dirty entry. The stimulus builds this chain in order: it loads the slot, tries to drain it during the fill, finishes the fill, serves a burst read from the slot, and only then issues the matching write and retries it. After the retry it checks that the rolled-back fields show the entry as it was at fill start.

// File: rtl/cob_fill_ctl.sv
module cob_fill_ctl #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              retry,
  input  logic              fill_done,
  input  logic              drain_done,
  output logic              fill_start,
  output logic              fill_cancel,
  output logic              cob_serve,
  output logic              restore_vld,
  output logic [TAG_W-1:0]  restore_tag,
  output logic              restore_valid,
  output logic              restore_dirty,
  output logic [IDX_W-1:0]  restore_idx,
  output logic              cob_valid,
  output logic [LINE_W-1:0] cob_line
);

  logic busy, hold;
  logic [TAG_W-1:0] sv_tag;
  logic [IDX_W-1:0] sv_idx;
  logic sv_valid, sv_dirty;

  wire [TAG_W-1:0]  req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  req_idx  = req_addr[OFF_W +: IDX_W];
  wire [LINE_W-1:0] req_line = req_addr[ADDR_W-1 -: LINE_W];

  wire take      = req_vld && !busy;
  wire lk_hit    = lk_valid && (lk_tag == req_tag);
  wire cob_hit   = cob_valid && (cob_line == req_line);
  wire dirty_vic = lk_valid && lk_dirty;
  wire serve_c   = take && !lk_hit && cob_hit && !req_write && req_burst;
  wire miss_fill = take && !lk_hit && !serve_c;
  wire blocked   = dirty_vic && cob_valid && !(req_write && cob_hit);
  wire start_c   = miss_fill && !blocked;
  wire refuse_c  = miss_fill && blocked;
  wire load_c    = start_c && dirty_vic;
  wire roll      = busy && retry;
  wire done      = busy && !retry && fill_done;

  assign restore_tag   = sv_tag;
  assign restore_valid = sv_valid;
  assign restore_dirty = sv_dirty;
  assign restore_idx   = sv_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_start  <= 1'b0;
      fill_cancel <= 1'b0;
      cob_serve   <= 1'b0;
      restore_vld <= 1'b0;
      busy        <= 1'b0;
      hold        <= 1'b0;
      sv_tag      <= '0;
      sv_idx      <= '0;
      sv_valid    <= 1'b0;
      sv_dirty    <= 1'b0;
      cob_valid   <= 1'b0;
      cob_line    <= '0;
    end else begin
      fill_start  <= start_c;
      fill_cancel <= refuse_c || roll;
      cob_serve   <= serve_c;
      restore_vld <= roll && hold;

      if (start_c) begin
        busy     <= 1'b1;
        hold     <= dirty_vic;
        sv_tag   <= lk_tag;
        sv_idx   <= req_idx;
        sv_valid <= lk_valid;
        sv_dirty <= lk_dirty;
      end else if (roll || done) begin
        busy <= 1'b0;
        hold <= 1'b0;
      end

      if (load_c) begin
        cob_valid <= 1'b1;
        cob_line  <= {lk_tag, req_idx};
      end else if (roll && hold) begin
        cob_valid <= 1'b0;
      end else if (drain_done && !hold) begin
        cob_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cob_fill_ctl_chk.sv
module cob_fill_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic fill_start,
  input logic fill_cancel,
  input logic cob_serve,
  input logic restore_vld,
  input logic cob_valid,
  input logic drain_done
);

  a_r5_start_or_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_start && fill_cancel));

  a_r7_serve_alone: assert property (@(posedge clk) disable iff (!rst_n)
    cob_serve |-> !fill_start && !fill_cancel);

  a_r8_restore_empties: assert property (@(posedge clk) disable iff (!rst_n)
    restore_vld |-> fill_cancel && !cob_valid);

  a_r4_load_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cob_valid) |-> fill_start);

  a_r10_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cob_valid) |-> restore_vld || $past(drain_done));

  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restore_vld |-> !fill_start && !cob_serve);

endmodule

bind cob_fill_ctl cob_fill_ctl_chk chk_i (.*);

// File: tb/cob_fill_ctl_tb.sv
module cob_fill_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_vld = 0, req_write = 0, req_burst = 0;
  logic [15:0] req_addr = '0;
  logic        lk_valid = 0, lk_dirty = 0;
  logic [7:0]  lk_tag = '0;
  logic        retry = 0, fill_done = 0, drain_done = 0;
  logic        fill_start, fill_cancel, cob_serve, restore_vld;
  logic [7:0]  restore_tag;
  logic        restore_valid, restore_dirty;
  logic [3:0]  restore_idx;
  logic        cob_valid;
  logic [11:0] cob_line;

  cob_fill_ctl dut_i (.*);

  typedef struct {
    logic st, cn, sv, rv, cv;
    logic [11:0] cl;
    logic [7:0] rt;
    logic rva, rdi;
    logic [3:0] ri;
    string tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  function automatic exp_t ex(logic st, logic cn, logic sv, logic rv, logic cv,
      logic [11:0] cl, logic [7:0] rt, logic rva, logic rdi, logic [3:0] ri, string tag);
    exp_t e;
    e.st = st; e.cn = cn; e.sv = sv; e.rv = rv; e.cv = cv; e.cl = cl;
    e.rt = rt; e.rva = rva; e.rdi = rdi; e.ri = ri; e.tag = tag;
    return e;
  endfunction

  function automatic logic [15:0] ad(logic [7:0] t, logic [3:0] i);
    return {t, i, 4'h0};
  endfunction

  task automatic drive(logic rv, logic [15:0] a, logic w, logic b, logic lv, logic ld,
      logic [7:0] lt, logic rt, logic fd, logic dd, exp_t e);
    @(negedge clk);
    req_vld = rv; req_addr = a; req_write = w; req_burst = b;
    lk_valid = lv; lk_dirty = ld; lk_tag = lt;
    retry = rt; fill_done = fd; drain_done = dd;
    q.push_back(e);
  endtask

  task automatic bad(string tag, string what, int act, int exp);
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        bit m;
        e = q.pop_front();
        m = 0;
        compared++;
        if (fill_start !== e.st) begin m = 1; bad(e.tag, "fill_start", fill_start, e.st); end
        if (fill_cancel !== e.cn) begin m = 1; bad(e.tag, "fill_cancel", fill_cancel, e.cn); end
        if (cob_serve !== e.sv) begin m = 1; bad(e.tag, "cob_serve", cob_serve, e.sv); end
        if (restore_vld !== e.rv) begin m = 1; bad(e.tag, "restore_vld", restore_vld, e.rv); end
        if (cob_valid !== e.cv) begin m = 1; bad(e.tag, "cob_valid", cob_valid, e.cv); end
        if (e.cv && cob_line !== e.cl) begin m = 1; bad(e.tag, "cob_line", cob_line, e.cl); end
        if (e.rv) begin
          if (restore_tag !== e.rt) begin m = 1; bad(e.tag, "restore_tag", restore_tag, e.rt); end
          if (restore_valid !== e.rva) begin m = 1; bad(e.tag, "restore_valid", restore_valid, e.rva); end
          if (restore_dirty !== e.rdi) begin m = 1; bad(e.tag, "restore_dirty", restore_dirty, e.rdi); end
          if (restore_idx !== e.ri) begin m = 1; bad(e.tag, "restore_idx", restore_idx, e.ri); end
        end
        if (m) mismatched++;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    compared++;
    mismatched++;
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ex(0,0,0,0,0, 0, 0,0,0,0, "R1 reset"));
    // R2 hit
    drive(1, ad(8'h11,3), 0, 1, 1, 1, 8'h11, 0, 0, 0, ex(0,0,0,0,0, 0, 0,0,0,0, "R2 hit"));
    // R3 clean victim, empty slot
    drive(1, ad(8'h22,5), 0, 0, 1, 0, 8'h33, 0, 0, 0, ex(1,0,0,0,0, 0, 0,0,0,0, "R3 clean miss"));
    // R11 request during fill ignored
    drive(1, ad(8'h44,6), 1, 1, 1, 1, 8'h45, 0, 0, 0, ex(0,0,0,0,0, 0, 0,0,0,0, "R11 busy ignore"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, ex(0,0,0,0,0, 0, 0,0,0,0, "R11 fill done"));
    // R4 dirty victim loads slot
    drive(1, ad(8'h40,2), 1, 0, 1, 1, 8'h55, 0, 0, 0, ex(1,0,0,0,1, 12'h552, 0,0,0,0, "R4 load"));
    // R10 drain ignored during loading fill
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ex(0,0,0,0,1, 12'h552, 0,0,0,0, "R10 drain in fill"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, ex(0,0,0,0,1, 12'h552, 0,0,0,0, "R11 fill done 2"));
    // R5 dirty victim, slot full
    drive(1, ad(8'h66,7), 0, 1, 1, 1, 8'h77, 0, 0, 0, ex(0,1,0,0,1, 12'h552, 0,0,0,0, "R5 refuse read"));
    // R7 burst read hits slot
    drive(1, ad(8'h55,2), 0, 1, 1, 0, 8'h40, 0, 0, 0, ex(0,0,1,0,1, 12'h552, 0,0,0,0, "R7 serve"));
    // R3 invalid victim while slot full
    drive(1, ad(8'h88,9), 0, 0, 0, 0, 8'h00, 0, 0, 0, ex(1,0,0,0,1, 12'h552, 0,0,0,0, "R3 full slot"));
    // R9 / R12 retry beats fill_done on a clean fill
    drive(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, ex(0,1,0,0,1, 12'h552, 0,0,0,0, "R9 R12 clean retry"));
    // R6 write hitting slot line with dirty victim
    drive(1, ad(8'h55,2), 1, 1, 1, 1, 8'h40, 0, 0, 0, ex(1,0,0,0,1, 12'h402, 0,0,0,0, "R6 write exception"));
    // R8 retry rolls back the burst-write fill
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, ex(0,1,0,1,0, 0, 8'h40,1,1,4'h2, "R8 rollback write"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ex(0,0,0,0,0, 0, 0,0,0,0, "R8 after rollback"));
    // R10 drain clears slot when idle
    drive(1, ad(8'h12,1), 0, 0, 1, 1, 8'h34, 0, 0, 0, ex(1,0,0,0,1, 12'h341, 0,0,0,0, "R4 load 2"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, ex(0,0,0,0,1, 12'h341, 0,0,0,0, "R11 fill done 3"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ex(0,0,0,0,0, 0, 0,0,0,0, "R10 drain idle"));
    // R8 / R12 retry with fill_done on a loading fill
    drive(1, ad(8'h13,4), 0, 1, 1, 1, 8'h35, 0, 0, 0, ex(1,0,0,0,1, 12'h354, 0,0,0,0, "R4 load 3"));
    drive(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, ex(0,1,0,1,0, 0, 8'h35,1,1,4'h4, "R8 R12 rollback"));
    // R5 write to another line while slot full
    drive(1, ad(8'hAA,6), 1, 0, 1, 1, 8'hBC, 0, 0, 0, ex(1,0,0,0,1, 12'hBC6, 0,0,0,0, "R4 load 4"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, ex(0,0,0,0,1, 12'hBC6, 0,0,0,0, "R11 fill done 4"));
    drive(1, ad(8'hBB,6), 1, 1, 1, 1, 8'hAA, 0, 0, 0, ex(0,1,0,0,1, 12'hBC6, 0,0,0,0, "R5 refuse write"));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ex(0,0,0,0,1, 12'hBC6, 0,0,0,0, "R5 slot kept"));
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
      compared++;
      mismatched++;
    end
    finish_run();
  end
endmodule